// File: doc/BRIEF.md
# Configurable I/O Pin Router

This block connects a set of on-chip function signals to a smaller set of I/O pads. Every pad has its own configuration word, written and read back over a simple addressed register port. The word holds a 2-bit slot select and a group of pad-control fields. Slot 0 of every pad belongs to that pad's own GPIO line. Slots 1 to 3 belong to shared functions, with the function index given by `(pad + slot) mod NUM_FN`. Each shared function has a fixed kind, set by the `FN_KINDS` parameter: output-only, input-only, or bus.

On the output side, one select value chooses both the value driven to the pad and its output-enable, using the same slot ordering. A bus function supplies its own output-enable. An output-only function always enables the pad. An input-only function leaves the pad undriven. On the input side, each function input has a priority selector over every pad that currently selects it, so several pads can never contend for one input. The pad-control fields go straight to the pad-control outputs without any muxing.

This is pure routing logic with no state machine. The only state is the bank of configuration registers.

Top module: `pin_router`

## Requirements
- R1: After reset, every configuration word reads back as 0. Every pad therefore selects slot 0, and its pull-up, pull-down and open-drain outputs are 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` in the word of pad `cfg_addr` at the clock edge. `cfg_rdata` shows the word of the pad addressed at that moment. A write leaves the words of all other pads unchanged.
- R3: A pad with select 0 drives `pad_out[p]` from `gpio_out[p]` and `pad_oe[p]` from `gpio_oe[p]`.
- R4: A pad with select s from 1 to 3 is routed to function f = (p + s) mod NUM_FN, where the kind of f sits in `FN_KINDS[2f+1:2f]` (0 output-only, 1 input-only, 2 bus). The routed values are:
  - output-only: out = `fn_out[f]`, oe = 1.
  - input-only: out = 0, oe = 0.
  - bus: out = `fn_out[f]`, oe = `fn_oe[f]`.
  
  With the default parameters, the kinds are: f0 output-only, f1 input-only, f2 bus, f3 input-only.
- R5: `gpio_in[p]` equals `pad_in[p]` when pad p has select 0, and 0 otherwise.
- R6: For an input-only or bus function f, `fn_in[f]` equals `pad_in` of the lowest-numbered pad whose select maps to f.
- R7: `fn_in[f]` is 0 when no pad selects f. It is always 0 for an output-only function.
- R8: The control fields pass straight through from the configuration word:
  - word bits [3:2] to `pad_drive[2p+1:2p]`
  - word bits [5:4] to `pad_hyst[2p+1:2p]`
  - bit 6 to `pad_od[p]`
  - bit 7 to `pad_pu[p]`
  - bit 8 to `pad_pd[p]`
  
  Word bits [1:0] are the select.
- R9: One function may drive several pads at once, and every pad that selects it shows the same routed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Pad index for write and read |
| cfg_wdata | input | 9 | Configuration word to store |
| cfg_rdata | output | 9 | Configuration word of the addressed pad |
| gpio_out | input | NUM_PADS | GPIO output value per pad |
| gpio_oe | input | NUM_PADS | GPIO output-enable per pad |
| gpio_in | output | NUM_PADS | GPIO input value per pad |
| fn_out | input | NUM_FN | Shared function output values |
| fn_oe | input | NUM_FN | Shared function output-enables (used by bus kinds) |
| fn_in | output | NUM_FN | Shared function input values |
| pad_in | input | NUM_PADS | Level seen at each pad |
| pad_out | output | NUM_PADS | Value driven to each pad |
| pad_oe | output | NUM_PADS | Output-enable of each pad |
| pad_drive | output | 2*NUM_PADS | Drive strength per pad |
| pad_hyst | output | 2*NUM_PADS | Hysteresis level per pad |
| pad_od | output | NUM_PADS | Open-drain select per pad |
| pad_pu | output | NUM_PADS | Pull-up enable per pad |
| pad_pd | output | NUM_PADS | Pull-down enable per pad |

## Verification
The bench sweeps all 256 select combinations of the four pads, and for each one all 16 pad-input patterns, comparing against an arithmetic model of the routing.

The sweep includes every case where two or three pads claim the same function input. A design that picks the wrong pad in such a case, or ORs the pads together, shows a wrong `fn_in` whenever the claiming pads disagree. A design that used the slot number instead of the function index, or reversed the modular mapping, drives functions to the wrong pads.

Directed cases cover reset clearing, write isolation between pads, one function fanned out to three pads, and bit positions of the control fields. A field shifted by one bit would show on the wrong pad-control output.

// File: rtl/pin_router_pkg.sv
package pin_router_pkg;

    localparam int SEL_W = 2;
    localparam int SLOTS = 1 << SEL_W;

    typedef enum logic [1:0] {
        FK_OUT = 2'd0,
        FK_IN  = 2'd1,
        FK_BUS = 2'd2
    } fn_kind_e;

    typedef struct packed {
        logic             pull_dn;
        logic             pull_up;
        logic             open_drn;
        logic [1:0]       hyst;
        logic [1:0]       drive;
        logic [SEL_W-1:0] sel;
    } pad_cfg_t;

    function automatic int route_fn(input int pad, input int slot, input int nfn);
        return (pad + slot) % nfn;
    endfunction

endpackage

// File: rtl/pad_cfg_bank.sv
module pad_cfg_bank
    import pin_router_pkg::*;
#(
    parameter int NUM_PADS = 4,
    parameter int ADDR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  pad_cfg_t          wdata,
    output pad_cfg_t          rdata,
    output pad_cfg_t          cfg_q [NUM_PADS]
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PADS; p++) begin
                cfg_q[p] <= '0;
            end
        end else if (we) begin
            for (int p = 0; p < NUM_PADS; p++) begin
                if (addr == ADDR_W'(p)) begin
                    cfg_q[p] <= wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PADS; p++) begin
            if (addr == ADDR_W'(p)) begin
                rdata = cfg_q[p];
            end
        end
    end

endmodule

// File: rtl/pad_out_mux.sv
module pad_out_mux
    import pin_router_pkg::*;
#(
    parameter int             NUM_FN   = 4,
    parameter int             PAD_IDX  = 0,
    parameter logic [2*NUM_FN-1:0] FN_KINDS = '0
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              gpio_out,
    input  logic              gpio_oe,
    input  logic [NUM_FN-1:0] fn_out,
    input  logic [NUM_FN-1:0] fn_oe,
    output logic              out,
    output logic              oe
);

    logic [SLOTS-1:0] cand_out;
    logic [SLOTS-1:0] cand_oe;
    logic             unused_fn;

    assign cand_out[0] = gpio_out;
    assign cand_oe[0]  = gpio_oe;
    assign unused_fn   = ^{fn_out, fn_oe};

    for (genvar s = 1; s < SLOTS; s++) begin : g_slot
        localparam int       F = route_fn(PAD_IDX, s, NUM_FN);
        localparam fn_kind_e K = fn_kind_e'(FN_KINDS[2*F +: 2]);
        if (K == FK_OUT) begin : g_out
            assign cand_out[s] = fn_out[F];
            assign cand_oe[s]  = 1'b1;
        end else if (K == FK_BUS) begin : g_bus
            assign cand_out[s] = fn_out[F];
            assign cand_oe[s]  = fn_oe[F];
        end else begin : g_in
            assign cand_out[s] = 1'b0;
            assign cand_oe[s]  = 1'b0;
        end
    end

    assign out = cand_out[sel];
    assign oe  = cand_oe[sel];

endmodule

// File: rtl/fn_in_prio.sv
module fn_in_prio
    import pin_router_pkg::*;
#(
    parameter int             NUM_PADS = 4,
    parameter int             NUM_FN   = 4,
    parameter int             FN_IDX   = 0,
    parameter logic [2*NUM_FN-1:0] FN_KINDS = '0
) (
    input  logic [SEL_W-1:0]    sel [NUM_PADS],
    input  logic [NUM_PADS-1:0] pad_in,
    output logic                fn_in
);

    localparam fn_kind_e KIND = fn_kind_e'(FN_KINDS[2*FN_IDX +: 2]);

    logic [NUM_PADS-1:0][SLOTS-1:0] slot_hit;
    logic [NUM_PADS-1:0]            hit;

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        assign slot_hit[p][0] = 1'b0;
        for (genvar s = 1; s < SLOTS; s++) begin : g_slot
            localparam bit MAPS = (route_fn(p, s, NUM_FN) == FN_IDX);
            assign slot_hit[p][s] = MAPS && (sel[p] == SEL_W'(s));
        end
        assign hit[p] = |slot_hit[p];
    end

    if (KIND == FK_OUT) begin : g_no_input
        logic unused_in;
        assign unused_in = ^{hit, pad_in};
        assign fn_in = 1'b0;
    end else begin : g_prio
        always_comb begin
            fn_in = 1'b0;
            for (int p = NUM_PADS - 1; p >= 0; p--) begin
                if (hit[p]) begin
                    fn_in = pad_in[p];
                end
            end
        end
    end

endmodule

// File: rtl/pin_router.sv
module pin_router
    import pin_router_pkg::*;
#(
    parameter int                  NUM_PADS = 4,
    parameter int                  NUM_FN   = 4,
    parameter logic [2*NUM_FN-1:0] FN_KINDS = 8'b01_10_01_00,
    localparam int                 ADDR_W   = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1,
    localparam int                 CFG_W    = $bits(pad_cfg_t)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [CFG_W-1:0]      cfg_wdata,
    output logic [CFG_W-1:0]      cfg_rdata,
    input  logic [NUM_PADS-1:0]   gpio_out,
    input  logic [NUM_PADS-1:0]   gpio_oe,
    output logic [NUM_PADS-1:0]   gpio_in,
    input  logic [NUM_FN-1:0]     fn_out,
    input  logic [NUM_FN-1:0]     fn_oe,
    output logic [NUM_FN-1:0]     fn_in,
    input  logic [NUM_PADS-1:0]   pad_in,
    output logic [NUM_PADS-1:0]   pad_out,
    output logic [NUM_PADS-1:0]   pad_oe,
    output logic [2*NUM_PADS-1:0] pad_drive,
    output logic [2*NUM_PADS-1:0] pad_hyst,
    output logic [NUM_PADS-1:0]   pad_od,
    output logic [NUM_PADS-1:0]   pad_pu,
    output logic [NUM_PADS-1:0]   pad_pd
);

    pad_cfg_t                  cfg_q [NUM_PADS];
    pad_cfg_t                  rd_word;
    logic [SEL_W-1:0]          sel_arr [NUM_PADS];
    logic [SEL_W*NUM_PADS-1:0] sel_flat;

    pad_cfg_bank #(
        .NUM_PADS (NUM_PADS),
        .ADDR_W   (ADDR_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (pad_cfg_t'(cfg_wdata)),
        .rdata (rd_word),
        .cfg_q (cfg_q)
    );

    assign cfg_rdata = rd_word;

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        assign sel_arr[p]               = cfg_q[p].sel;
        assign sel_flat[SEL_W*p +: SEL_W] = cfg_q[p].sel;
        assign gpio_in[p]               = pad_in[p] & (cfg_q[p].sel == '0);
        assign pad_drive[2*p +: 2]      = cfg_q[p].drive;
        assign pad_hyst[2*p +: 2]       = cfg_q[p].hyst;
        assign pad_od[p]                = cfg_q[p].open_drn;
        assign pad_pu[p]                = cfg_q[p].pull_up;
        assign pad_pd[p]                = cfg_q[p].pull_dn;

        pad_out_mux #(
            .NUM_FN   (NUM_FN),
            .PAD_IDX  (p),
            .FN_KINDS (FN_KINDS)
        ) u_omux (
            .sel      (cfg_q[p].sel),
            .gpio_out (gpio_out[p]),
            .gpio_oe  (gpio_oe[p]),
            .fn_out   (fn_out),
            .fn_oe    (fn_oe),
            .out      (pad_out[p]),
            .oe       (pad_oe[p])
        );
    end

    for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
        fn_in_prio #(
            .NUM_PADS (NUM_PADS),
            .NUM_FN   (NUM_FN),
            .FN_IDX   (f),
            .FN_KINDS (FN_KINDS)
        ) u_imux (
            .sel    (sel_arr),
            .pad_in (pad_in),
            .fn_in  (fn_in[f])
        );
    end

endmodule

// File: rtl/pin_router_chk.sv
module pin_router_chk
    import pin_router_pkg::*;
#(
    parameter int                  NUM_PADS = 4,
    parameter int                  NUM_FN   = 4,
    parameter logic [2*NUM_FN-1:0] FN_KINDS = '0,
    parameter int                  ADDR_W   = 2,
    parameter int                  CFG_W    = 9
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [ADDR_W-1:0]         cfg_addr,
    input logic [CFG_W-1:0]          cfg_wdata,
    input logic [CFG_W-1:0]          cfg_rdata,
    input logic [NUM_PADS-1:0]       gpio_out,
    input logic [NUM_PADS-1:0]       gpio_oe,
    input logic [NUM_PADS-1:0]       gpio_in,
    input logic [NUM_FN-1:0]         fn_in,
    input logic [NUM_PADS-1:0]       pad_in,
    input logic [NUM_PADS-1:0]       pad_out,
    input logic [NUM_PADS-1:0]       pad_oe,
    input logic [NUM_PADS-1:0]       pad_od,
    input logic [NUM_PADS-1:0]       pad_pu,
    input logic [NUM_PADS-1:0]       pad_pd,
    input logic [SEL_W*NUM_PADS-1:0] sel_flat
);

    // R1
    rst_clear_chk: assert property (@(posedge clk) !rst_n |=> cfg_rdata == '0);

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata)));

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        // R3
        gpio_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[SEL_W*p +: SEL_W] == '0) |->
                (pad_out[p] == gpio_out[p]) && (pad_oe[p] == gpio_oe[p]));

        // R5
        gpio_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gpio_in[p] |-> pad_in[p] && (sel_flat[SEL_W*p +: SEL_W] == '0));

        // R8
        ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_addr == ADDR_W'(p)) |=> $stable({pad_od[p], pad_pu[p], pad_pd[p]}));
    end

    for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
        localparam fn_kind_e K = fn_kind_e'(FN_KINDS[2*f +: 2]);
        logic [NUM_PADS-1:0] claim;
        always_comb begin
            claim = '0;
            for (int p = 0; p < NUM_PADS; p++) begin
                for (int s = 1; s < SLOTS; s++) begin
                    if (route_fn(p, s, NUM_FN) == f && sel_flat[SEL_W*p +: SEL_W] == SEL_W'(s)) begin
                        claim[p] = 1'b1;
                    end
                end
            end
        end
        if (K == FK_OUT) begin : g_out
            // R7
            out_fn_in_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !fn_in[f]);
        end else begin : g_in
            // R6
            fn_in_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fn_in[f] |-> |(claim & pad_in));
        end
    end

endmodule

bind pin_router pin_router_chk #(
    .NUM_PADS (NUM_PADS),
    .NUM_FN   (NUM_FN),
    .FN_KINDS (FN_KINDS),
    .ADDR_W   (ADDR_W),
    .CFG_W    (CFG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .gpio_out  (gpio_out),
    .gpio_oe   (gpio_oe),
    .gpio_in   (gpio_in),
    .fn_in     (fn_in),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_od    (pad_od),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .sel_flat  (sel_flat)
);

// File: tb/tb_pin_router.sv
module tb_pin_router;

    localparam int NP = 4;
    localparam int NF = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [8:0]    cfg_wdata = '0;
    logic [8:0]    cfg_rdata;
    logic [NP-1:0] gpio_out = '0, gpio_oe = '0, gpio_in;
    logic [NF-1:0] fn_out = '0, fn_oe = '0, fn_in;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe, pad_od, pad_pu, pad_pd;
    logic [2*NP-1:0] pad_drive, pad_hyst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [1:0] sel_m [NP];

    always #2 clk = ~clk;

    pin_router dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_in(gpio_in),
        .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_drive(pad_drive), .pad_hyst(pad_hyst),
        .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    // kinds from R4: f0 output-only, f1 input-only, f2 bus, f3 input-only
    function automatic int kind_of(input int f);
        case (f)
            0: return 0;
            2: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int fmap(input int p, input int s);
        return (p + s) % NF;
    endfunction

    function automatic logic exp_out(input int p);
        int f;
        if (sel_m[p] == 0) return gpio_out[p];
        f = fmap(p, int'(sel_m[p]));
        if (kind_of(f) == 1) return 1'b0;
        return fn_out[f];
    endfunction

    function automatic logic exp_oe(input int p);
        int f;
        if (sel_m[p] == 0) return gpio_oe[p];
        f = fmap(p, int'(sel_m[p]));
        if (kind_of(f) == 0) return 1'b1;
        if (kind_of(f) == 1) return 1'b0;
        return fn_oe[f];
    endfunction

    function automatic logic exp_fin(input int f);
        if (kind_of(f) == 0) return 1'b0;
        for (int p = 0; p < NP; p++) begin
            if (sel_m[p] != 0 && fmap(p, int'(sel_m[p])) == f) return pad_in[p];
        end
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int p, input logic [8:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(p); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        sel_m[p] = d[1:0];
    endtask

    task automatic rd_check(input string tag, input int p, input logic [8:0] exp);
        @(negedge clk);
        cfg_addr = 2'(p);
        #1;
        check(tag, 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic check_routes(input string tag);
        logic [NP-1:0] eo, ee, eg;
        logic [NF-1:0] ef;
        for (int p = 0; p < NP; p++) begin
            eo[p] = exp_out(p);
            ee[p] = exp_oe(p);
            eg[p] = (sel_m[p] == 0) & pad_in[p];
        end
        for (int f = 0; f < NF; f++) ef[f] = exp_fin(f);
        check({tag, " R4 pad_out"}, 32'(pad_out), 32'(eo));
        check({tag, " R4 pad_oe"}, 32'(pad_oe), 32'(ee));
        check({tag, " R5 gpio_in"}, 32'(gpio_in), 32'(eg));
        check({tag, " R6 R7 fn_in"}, 32'(fn_in), 32'(ef));
    endtask

    initial begin
        for (int p = 0; p < NP; p++) sel_m[p] = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int p = 0; p < NP; p++) rd_check("R1 rdata", p, 9'd0);
        check("R1 pulls/od", 32'({pad_pu, pad_pd, pad_od}), 32'd0);

        // R3: all pads on GPIO slot
        @(negedge clk);
        gpio_out = 4'b1010; gpio_oe = 4'b0110; pad_in = 4'b1101; fn_out = 4'hF; fn_oe = 4'hF;
        #1;
        check("R3 pad_out", 32'(pad_out), 32'h0A);
        check("R3 pad_oe", 32'(pad_oe), 32'h06);
        check("R5 gpio_in", 32'(gpio_in), 32'h0D);
        check("R7 fn_in none", 32'(fn_in), 32'h0);

        // R2 and R8: distinct words, isolation, field positions
        for (int p = 0; p < NP; p++) wr(p, 9'((p * 91 + 60) & 9'h1FC));
        wr(1, 9'h155 & 9'h1FC);
        for (int p = 0; p < NP; p++) begin
            logic [8:0] w;
            w = (p == 1) ? (9'h155 & 9'h1FC) : 9'((p * 91 + 60) & 9'h1FC);
            rd_check("R2 readback", p, w);
            check("R8 drive", 32'(pad_drive[2*p +: 2]), 32'(w[3:2]));
            check("R8 hyst", 32'(pad_hyst[2*p +: 2]), 32'(w[5:4]));
            check("R8 od/pu/pd", 32'({pad_od[p], pad_pu[p], pad_pd[p]}), 32'({w[6], w[7], w[8]}));
        end

        // R9: function 2 (bus) on pads 0,1,3
        wr(0, 9'd2); wr(1, 9'd1); wr(2, 9'd0); wr(3, 9'd3);
        @(negedge clk);
        fn_out = 4'b0100; fn_oe = 4'b0100; gpio_out = 4'b0000; gpio_oe = 4'b0000;
        #1;
        check("R9 fanout out", 32'(pad_out), 32'h0B);
        check("R9 fanout oe", 32'(pad_oe), 32'h0B);

        // R6: function 1 claimed by pads 0,2,3
        wr(0, 9'd1); wr(2, 9'd3); wr(3, 9'd2);
        @(negedge clk); pad_in = 4'b1100; #1;
        check("R6 prio low pad 0", 32'(fn_in[1]), 32'd0);
        @(negedge clk); pad_in = 4'b0001; #1;
        check("R6 prio pad0 high", 32'(fn_in[1]), 32'd1);

        // Sweep over all select combinations and pad inputs
        for (int c = 0; c < 256; c++) begin
            for (int p = 0; p < NP; p++) begin
                wr(p, 9'({7'((c * 7 + p * 3) & 7'h7F), 2'((c >> (2 * p)) & 3)}));
            end
            for (int p = 0; p < NP; p++) begin
                logic [6:0] ctl;
                ctl = 7'((c * 7 + p * 3) & 7'h7F);
                check("R8 sweep", 32'({pad_pd[p], pad_pu[p], pad_od[p], pad_hyst[2*p +: 2], pad_drive[2*p +: 2]}),
                      32'(ctl));
            end
            for (int pin = 0; pin < 16; pin++) begin
                @(negedge clk);
                pad_in   = 4'(pin);
                fn_out   = 4'(pin) ^ 4'(c);
                fn_oe    = ~4'(pin) ^ 4'(c >> 4);
                gpio_out = {4'(pin)} >> 1 | 4'((pin & 1) << 3);
                gpio_oe  = 4'(c) ^ 4'hA;
                #1;
                check_routes("R3 R9 sweep");
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule